// File: doc/BRIEF.md
# Pin Interrupt and Wake Detector

This unit watches a bank of already-synchronized input pins and turns selected pin activity into a pending flag per pin, a combined interrupt request and a wake request. Software configures it through a simple register port. The port carries an address, write data and a write strobe. Read data comes back combinationally for the address presented.

Each pin can watch for a level or for an edge. A polarity bit chooses high/rising or low/falling. A both-edges bit makes an edge-mode pin fire on either transition. A pin's trigger becomes a sticky pending flag only where its interrupt enable is set. Software clears the flags by writing ones. The wake request comes straight from the trigger of any wake-enabled pin, whatever the interrupt enables are. Both the interrupt enable word and the wake enable word have write-one set and write-one clear aliases, so single bits can change without a read-modify-write.

Top module: `gpio_irq_wake`

## Requirements
- R1: After reset every control word (trigger style, polarity, both-edges, interrupt enable, wake enable) and every pending flag is zero, and irq_o and wake_o are low.
- R2: Trigger style (0x28), polarity (0x2C), both-edges (0x5C), interrupt enable (0x34) and wake enable (0x4C) read back the last value written at their offset. Any unmapped offset reads zero.
- R3: Writing to 0x38 sets, and writing to 0x3C clears, the interrupt enable bits where the data has a one. Offsets 0x50 and 0x54 do the same for wake enable. Bits where the data has a zero keep their value.
- R4: With its trigger-style bit at 0 (level), a pin fires while it is high if its polarity bit is 1, or while it is low if its polarity bit is 0.
- R5: With its trigger-style bit at 1 (edge), a pin fires on a 0-to-1 change against the previous cycle if its polarity bit is 1, or on a 1-to-0 change if it is 0. The opposite edge has no effect.
- R6: A both-edges bit of 1 makes an edge-mode pin fire on either transition, whatever its polarity. On a level-mode pin it has no effect.
- R7: A pending flag (read at 0x40) is set only for a firing pin whose interrupt enable bit is 1. Writes to 0x40 do not change the flags.
- R8: Writing ones to 0x48 clears the matching pending flags and leaves the others alone. If a pin fires in the same cycle as its clear, the flag stays set. A level-mode pin whose active level remains therefore stays pending.
- R9: irq_o is high exactly when at least one pending flag is set. It follows a firing pin by one clock.
- R10: wake_o is high in the same cycle that any pin fires while its wake enable bit is 1. This does not depend on the interrupt enables.
- R11: A pin that stays at a steady value across reset and configuration produces no edge event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Synchronized pin levels |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | OR of all pending flags |
| wake_o | output | 1 | OR of wake-enabled pin triggers |

## Verification
The embedded assertions check on every cycle that:
- a flag rises only where the interrupt enable was set;
- a firing, enabled pin is pending on the next cycle, even under a clear;
- a clear with no coinciding trigger empties the flag;
- a both-edges pin in edge mode fires on any change;
- wake_o stays low while no wake enable is set.

The exact decoding of trigger style against polarity needs the bench's directed scenarios. So do the rejection of the opposite edge, the null effect of the both-edges bit in level mode, the alias arithmetic, and the absence of a false edge after reset.

// File: rtl/gpio_iw_pkg.sv
package gpio_iw_pkg;
  localparam int OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_STYLE   = 8'h28;
  localparam logic [OFS_W-1:0] OFS_POL     = 8'h2C;
  localparam logic [OFS_W-1:0] OFS_IEN     = 8'h34;
  localparam logic [OFS_W-1:0] OFS_IEN_SET = 8'h38;
  localparam logic [OFS_W-1:0] OFS_IEN_CLR = 8'h3C;
  localparam logic [OFS_W-1:0] OFS_PEND    = 8'h40;
  localparam logic [OFS_W-1:0] OFS_ACK     = 8'h48;
  localparam logic [OFS_W-1:0] OFS_WEN     = 8'h4C;
  localparam logic [OFS_W-1:0] OFS_WEN_SET = 8'h50;
  localparam logic [OFS_W-1:0] OFS_WEN_CLR = 8'h54;
  localparam logic [OFS_W-1:0] OFS_BOTH    = 8'h5C;

  // Trigger rule for one pin: style 0 = level, 1 = edge.
  function automatic logic pin_fires(input logic use_edge, input logic act_hi,
                                     input logic both, input logic cur,
                                     input logic last);
    logic rise, fall;
    rise = cur & ~last;
    fall = ~cur & last;
    if (!use_edge) return act_hi ? cur : ~cur;
    if (both)      return rise | fall;
    return act_hi ? rise : fall;
  endfunction
endpackage

// File: rtl/gpio_iw_regs.sv
module gpio_iw_regs
  import gpio_iw_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [NPIN-1:0] wdata_i,
  input  logic            we_i,
  input  logic [NPIN-1:0] pend_i,
  output logic [NPIN-1:0] style_o,
  output logic [NPIN-1:0] pol_o,
  output logic [NPIN-1:0] both_o,
  output logic [NPIN-1:0] ien_o,
  output logic [NPIN-1:0] wen_o,
  output logic [NPIN-1:0] ack_o,
  output logic [NPIN-1:0] rdata_o
);
  logic [NPIN-1:0] style_q, pol_q, both_q, ien_q, wen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q <= '0;
      pol_q   <= '0;
      both_q  <= '0;
      ien_q   <= '0;
      wen_q   <= '0;
    end else if (we_i) begin
      case (addr_i)
        OFS_STYLE:   style_q <= wdata_i;
        OFS_POL:     pol_q   <= wdata_i;
        OFS_BOTH:    both_q  <= wdata_i;
        OFS_IEN:     ien_q   <= wdata_i;
        OFS_IEN_SET: ien_q   <= ien_q | wdata_i;
        OFS_IEN_CLR: ien_q   <= ien_q & ~wdata_i;
        OFS_WEN:     wen_q   <= wdata_i;
        OFS_WEN_SET: wen_q   <= wen_q | wdata_i;
        OFS_WEN_CLR: wen_q   <= wen_q & ~wdata_i;
        default: ;
      endcase
    end
  end

  assign ack_o = (we_i && addr_i == OFS_ACK) ? wdata_i : '0;

  always_comb begin
    case (addr_i)
      OFS_STYLE: rdata_o = style_q;
      OFS_POL:   rdata_o = pol_q;
      OFS_BOTH:  rdata_o = both_q;
      OFS_IEN:   rdata_o = ien_q;
      OFS_WEN:   rdata_o = wen_q;
      OFS_PEND:  rdata_o = pend_i;
      default:   rdata_o = '0;
    endcase
  end

  assign style_o = style_q;
  assign pol_o   = pol_q;
  assign both_o  = both_q;
  assign ien_o   = ien_q;
  assign wen_o   = wen_q;
endmodule

// File: rtl/gpio_iw_detect.sv
module gpio_iw_detect
  import gpio_iw_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] style_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] both_i,
  output logic [NPIN-1:0] fire_o
);
  // Previous pin value follows the pin in every cycle, reset included,
  // so leaving reset never shows an edge.
  logic [NPIN-1:0] last_q;

  always_ff @(posedge clk) last_q <= pin_i;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    assign fire_o[g] = pin_fires(style_i[g], pol_i[g], both_i[g],
                                 pin_i[g], last_q[g]);
  end

  AST_BOTH_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    ((style_i & both_i & (pin_i ^ last_q) & ~fire_o) == '0)); // R6
endmodule

// File: rtl/gpio_iw_pending.sv
module gpio_iw_pending #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] fire_i,
  input  logic [NPIN-1:0] ien_i,
  input  logic [NPIN-1:0] ack_i,
  output logic [NPIN-1:0] pend_o
);
  logic [NPIN-1:0] hit, pend_q;

  assign hit = fire_i & ien_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_i) | hit;
  end

  assign pend_o = pend_q;

  AST_RISE_NEEDS_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q) & ~$past(ien_i)) == '0)); // R7
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(fire_i & ien_i) & ~pend_q) == '0)); // R8
  AST_ACK_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_i & ~(fire_i & ien_i)) & pend_q) == '0)); // R8
endmodule

// File: rtl/gpio_irq_wake.sv
module gpio_irq_wake
  import gpio_iw_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [NPIN-1:0]  wdata_i,
  input  logic             we_i,
  output logic [NPIN-1:0]  rdata_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic [NPIN-1:0] style_w, pol_w, both_w, ien_w, wen_w, ack_w, fire_w, pend_w;

  gpio_iw_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .pend_i(pend_w), .style_o(style_w), .pol_o(pol_w), .both_o(both_w),
    .ien_o(ien_w), .wen_o(wen_w), .ack_o(ack_w), .rdata_o(rdata_o)
  );

  gpio_iw_detect #(.NPIN(NPIN)) u_detect (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .style_i(style_w),
    .pol_i(pol_w), .both_i(both_w), .fire_o(fire_w)
  );

  gpio_iw_pending #(.NPIN(NPIN)) u_pend (
    .clk(clk), .rst_n(rst_n), .fire_i(fire_w), .ien_i(ien_w),
    .ack_i(ack_w), .pend_o(pend_w)
  );

  assign irq_o  = |pend_w;
  assign wake_o = |(fire_w & wen_w);

  AST_WAKE_NEEDS_WEN: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_w == '0) |-> !wake_o); // R10
endmodule

// File: tb/sim_gpio_irq_wake.sv
`timescale 1ns/1ps
module sim_gpio_irq_wake;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = 32'hFFFF_FFFF;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq, wake;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_wake u0 (.clk(clk), .rst_n(rst_n), .pin_i(pin), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .irq_o(irq), .wake_o(wake));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic cleanup();
    pin = 32'hFFFF_FFFF;
    wr(8'h28, 0); wr(8'h2C, 0); wr(8'h5C, 0); wr(8'h34, 0); wr(8'h4C, 0);
    wr(8'h48, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    foreach (u0.rdata_o[i]) ; // no-op placeholder loop avoided
    rd(8'h28, v); chk("R1 style", v, 0);
    rd(8'h2C, v); chk("R1 pol", v, 0);
    rd(8'h5C, v); chk("R1 both", v, 0);
    rd(8'h34, v); chk("R1 ien", v, 0);
    rd(8'h4C, v); chk("R1 wen", v, 0);
    rd(8'h40, v); chk("R1 pend", v, 0);
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h28, 32'hA5A5_0F0F); rd(8'h28, v); chk("R2 style", v, 32'hA5A5_0F0F);
    wr(8'h2C, 32'h1234_5678); rd(8'h2C, v); chk("R2 pol", v, 32'h1234_5678);
    wr(8'h5C, 32'hCAFE_0001); rd(8'h5C, v); chk("R2 both", v, 32'hCAFE_0001);
    rd(8'h44, v); chk("R2 unmapped", v, 0);
    wr(8'h40, 32'hFFFF_FFFF); rd(8'h40, v); chk("R7 pend read-only", v, 0);
    cleanup();
  endtask

  task automatic t_alias();
    logic [31:0] v;
    wr(8'h34, 32'h0000_00F0); wr(8'h38, 32'h0000_000F);
    rd(8'h34, v); chk("R3 ien set", v, 32'h0000_00FF);
    wr(8'h3C, 32'h0000_003C); rd(8'h34, v); chk("R3 ien clr", v, 32'h0000_00C3);
    wr(8'h4C, 32'h8000_0000); wr(8'h50, 32'h0001_0000);
    rd(8'h4C, v); chk("R3 wen set", v, 32'h8001_0000);
    wr(8'h54, 32'h8000_0000); rd(8'h4C, v); chk("R3 wen clr", v, 32'h0001_0000);
    rd(8'h38, v); chk("R2 alias reads zero", v, 0);
    cleanup();
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(8'h34, 32'h0000_0003);
    @(negedge clk); pin[0] = 1'b0;   // active-low level on pin 0
    cyc(); rd(8'h40, v); chk("R4 low level", v, 32'h1); chk("R9 irq", irq, 1);
    wr(8'h48, 32'h1); rd(8'h40, v); chk("R8 set wins while level held", v, 32'h1);
    pin[0] = 1'b1; wr(8'h48, 32'h1); rd(8'h40, v); chk("R8 clear", v, 0);
    chk("R9 irq low", irq, 0);
    wr(8'h2C, 32'h0000_0002);        // pin 1 active high, pin is high
    cyc(); pin[1] = 1'b0; rd(8'h40, v); chk("R4 high level", v, 32'h2);
    pin[0] = 1'b0; cyc(); pin[0] = 1'b1;
    rd(8'h40, v); chk("R4 two flags", v, 32'h3);
    wr(8'h48, 32'h2); rd(8'h40, v); chk("R8 clear only one", v, 32'h1);
    cleanup();
  endtask

  task automatic t_edge();
    logic [31:0] v;
    wr(8'h28, 32'h10); wr(8'h2C, 32'h10); wr(8'h34, 32'h10);
    @(negedge clk); pin[4] = 1'b0; cyc(); cyc();
    rd(8'h40, v); chk("R5 falling ignored when rising", v, 0);
    pin[4] = 1'b1; cyc(); rd(8'h40, v); chk("R5 rising", v, 32'h10);
    cyc(); rd(8'h40, v); chk("R5 flag sticky", v, 32'h10);
    wr(8'h48, 32'h10); wr(8'h2C, 0);
    pin[4] = 1'b0; cyc(); rd(8'h40, v); chk("R5 falling", v, 32'h10);
    wr(8'h48, 32'h10); pin[4] = 1'b1; cyc(); cyc();
    rd(8'h40, v); chk("R5 rising ignored when falling", v, 0);
    wr(8'h5C, 32'h10);
    pin[4] = 1'b0; cyc(); rd(8'h40, v); chk("R6 both fall", v, 32'h10);
    wr(8'h48, 32'h10);
    pin[4] = 1'b1; cyc(); rd(8'h40, v); chk("R6 both rise", v, 32'h10);
    wr(8'h48, 32'h10);
    // Level mode with both-edges set: active low, release pin with a clear
    wr(8'h28, 0); pin[4] = 1'b0; cyc();
    @(negedge clk); pin[4] = 1'b1; addr = 8'h48; wdata = 32'h10; we = 1'b1;
    @(negedge clk); we = 1'b0;
    rd(8'h40, v); chk("R6 no effect in level mode", v, 0);
    cleanup();
  endtask

  task automatic t_wake();
    logic [31:0] v;
    wr(8'h2C, 32'h100);              // pin 8 level high active, ien 0
    cyc(); rd(8'h40, v); chk("R7 no flag without ien", v, 0);
    chk("R9 irq stays low", irq, 0);
    chk("R10 no wake without wen", wake, 0);
    wr(8'h50, 32'h100); #0.5; chk("R10 wake from level", wake, 1);
    wr(8'h54, 32'h100); #0.5; chk("R10 wake off", wake, 0);
    wr(8'h2C, 0);
    wr(8'h28, 32'h1000); wr(8'h2C, 32'h1000); wr(8'h4C, 32'h1000);
    pin[12] = 1'b0; cyc(); cyc();
    pin[12] = 1'b1; #0.5; chk("R10 wake same cycle as edge", wake, 1);
    cyc(); #0.5; chk("R10 wake ends after edge", wake, 0);
    cleanup();
  endtask

  task automatic t_noedge();
    logic [31:0] v;
    pin = 32'hFFFF_FFFF; rst_n = 1'b0; repeat (3) cyc(); rst_n = 1'b1;
    wr(8'h28, 32'h0010_0000); wr(8'h2C, 32'h0010_0000); wr(8'h34, 32'h0010_0000);
    cyc(); cyc(); rd(8'h40, v); chk("R11 no false edge", v, 0);
    chk("R11 irq low", irq, 0);
    cleanup();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_regs();
    t_alias();
    t_level();
    t_edge();
    t_wake();
    t_noedge();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule